// File: doc/BRIEF.md
# Byte-Addressed Program Counter with Upper-Byte Latches

This block holds the fetch address of a processor whose instructions are two bytes wide and whose program memory is addressed by byte. The counter is 21 bits wide. Bit 0 always stays 0, so the fetch address cannot land between two instructions. The counter moves to its next value from one of four sources: a sequential advance, a direct branch, call or goto load, a return load taken from the top of the return stack, or a software write to its low byte.

Software sees the counter through a small byte-wide register port. Only the low byte of the counter can be reached directly. The upper two bytes sit behind two latch registers. A write to the low byte loads the whole counter at once from the two latches and the written byte. A read of the low byte copies the counter's upper bits back into the two latches. This lets software do computed jumps and read the full address back in a consistent way. Hardware branch and return loads never touch the latches.

Top module: `pc_byte_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, both latches and `reg_rdata_o` all become 0.
- R2: With advance as the only active source, the counter grows by 2 and wraps from 0x1FFFFE to 0. Bit 0 of `fetch_addr_o` is always 0.
- R3: A register write with select 0 (counter low byte) loads the counter with {upper latch, high latch, written byte with bit 0 cleared} at that edge.
- R4: A register read with select 0 returns counter bits [7:0] in `reg_rdata_o` after the edge. At that same edge it copies counter bits [15:8] into the high latch and bits [20:16] into the upper latch.
- R5: A branch load sets the counter to `jmp_addr_i` with bit 0 cleared. Neither latch changes.
- R6: A return load sets the counter to `ret_addr_i` with bit 0 cleared. Neither latch changes.
- R7: Priority when sources coincide is reset, then return, then branch, then low-byte write, then advance. A low-byte write that loses leaves the counter untouched.
- R8: Selects 1 (counter high byte) and 2 (counter upper byte) always read as 0. Writes to them change nothing. Selects 5 to 7 behave the same way.
- R9: The upper latch (select 4) holds 5 bits. Written bits [7:5] are dropped and always read back as 0.
- R10: Select 3 reads and writes the high latch as a full byte. Select 4 reads the upper latch. Reading a latch changes no state. `reg_rdata_o` updates only on edges with `reg_rd_i` high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Sequential advance by one instruction |
| jmp_vld_i | input | 1 | Branch, call or goto load request |
| jmp_addr_i | input | 21 | Branch target |
| ret_vld_i | input | 1 | Return load request |
| ret_addr_i | input | 21 | Top of the return stack |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 3 | Register select (0 counter low, 1 counter high, 2 counter upper, 3 high latch, 4 upper latch) |
| reg_wdata_i | input | 8 | Register write data |
| fetch_addr_o | output | 21 | Current fetch address |
| reg_rdata_o | output | 8 | Registered read data |

## Verification
The assertions check the following on every cycle:
- the fetch address stays aligned;
- the counter holds when no source is active;
- advance, branch, return and software loads each land on the value they define, in priority order;
- the two counter-byte selects read as 0;
- the narrow upper latch never shows its top three bits.

Some behaviour only the bench's scenarios can show, because it depends on a history of register traffic rather than on one edge:
- the latch round trip, where a low-byte read refreshes both latches and a later low-byte write then rebuilds the full address from them;
- that branch and return loads leave the latches alone;
- the wrap at the top of the address space.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

  localparam int DEF_PC_W       = 21;
  localparam int DEF_BYTE_W     = 8;
  localparam int DEF_INSN_BYTES = 2;
  localparam int SEL_W          = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_PC_LO  = 3'd0,
    SEL_PC_HI  = 3'd1,
    SEL_PC_UP  = 3'd2,
    SEL_LAT_HI = 3'd3,
    SEL_LAT_UP = 3'd4
  } reg_sel_e;

  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_ADV  = 3'd1,
    SRC_SWLO = 3'd2,
    SRC_JMP  = 3'd3,
    SRC_RET  = 3'd4
  } load_src_e;

endpackage

// File: rtl/pcl_src_arb.sv
module pcl_src_arb
  import pcl_pkg::*;
(
  input  logic      adv,
  input  logic      jmp_vld,
  input  logic      ret_vld,
  input  logic      swlo_wr,
  output load_src_e src
);

  // Fixed priority: return, branch, software low-byte write, advance.
  always_comb begin
    if (ret_vld)      src = SRC_RET;
    else if (jmp_vld) src = SRC_JMP;
    else if (swlo_wr) src = SRC_SWLO;
    else if (adv)     src = SRC_ADV;
    else              src = SRC_HOLD;
  end

endmodule

// File: rtl/pcl_count_reg.sv
module pcl_count_reg
  import pcl_pkg::*;
#(
  parameter int PC_W       = DEF_PC_W,
  parameter int BYTE_W     = DEF_BYTE_W,
  parameter int INSN_BYTES = DEF_INSN_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  load_src_e          src,
  input  logic [PC_W-1:0]    jmp_addr,
  input  logic [PC_W-1:0]    ret_addr,
  input  logic [PC_W-2*BYTE_W-1:0] lat_up,
  input  logic [BYTE_W-1:0]  lat_hi,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [PC_W-1:0]    pc
);

  localparam logic [PC_W-1:0] STEP       = PC_W'(INSN_BYTES);
  localparam logic [PC_W-1:0] ALIGN_MASK = ~(PC_W'(INSN_BYTES - 1));

  logic [PC_W-1:0] pc_nxt;

  always_comb begin
    unique case (src)
      SRC_RET:  pc_nxt = ret_addr & ALIGN_MASK;
      SRC_JMP:  pc_nxt = jmp_addr & ALIGN_MASK;
      SRC_SWLO: pc_nxt = {lat_up, lat_hi, wdata} & ALIGN_MASK;
      SRC_ADV:  pc_nxt = pc + STEP;
      default:  pc_nxt = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nxt;
  end

endmodule

// File: rtl/pcl_latch_bank.sv
module pcl_latch_bank
  import pcl_pkg::*;
#(
  parameter int BYTE_W = DEF_BYTE_W,
  parameter int UP_W   = DEF_PC_W - 2 * DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_lo_rd,
  input  logic [UP_W+BYTE_W-1:0] pc_upper,
  input  logic              wr_hi,
  input  logic              wr_up,
  input  logic [BYTE_W-1:0] hi_wdata,
  input  logic [UP_W-1:0]   up_wdata,
  output logic [BYTE_W-1:0] lat_hi,
  output logic [UP_W-1:0]   lat_up
);

  // A low-byte read refreshes both latches from the counter; otherwise
  // software may write each latch on its own select.
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_hi <= '0;
      lat_up <= '0;
    end else if (cap_lo_rd) begin
      lat_hi <= pc_upper[BYTE_W-1:0];
      lat_up <= pc_upper[UP_W+BYTE_W-1:BYTE_W];
    end else begin
      if (wr_hi) lat_hi <= hi_wdata;
      if (wr_up) lat_up <= up_wdata;
    end
  end

endmodule

// File: rtl/pcl_rd_port.sv
module pcl_rd_port
  import pcl_pkg::*;
#(
  parameter int BYTE_W = DEF_BYTE_W,
  parameter int UP_W   = DEF_PC_W - 2 * DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] pc_lo,
  input  logic [BYTE_W-1:0] lat_hi,
  input  logic [UP_W-1:0]   lat_up,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] rd_mux;

  always_comb begin
    unique case (sel)
      SEL_PC_LO:  rd_mux = pc_lo;
      SEL_LAT_HI: rd_mux = lat_hi;
      SEL_LAT_UP: rd_mux = {{(BYTE_W-UP_W){1'b0}}, lat_up};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

endmodule

// File: rtl/pc_byte_counter.sv
module pc_byte_counter
  import pcl_pkg::*;
#(
  parameter int PC_W       = DEF_PC_W,
  parameter int BYTE_W     = DEF_BYTE_W,
  parameter int INSN_BYTES = DEF_INSN_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              jmp_vld_i,
  input  logic [PC_W-1:0]   jmp_addr_i,
  input  logic              ret_vld_i,
  input  logic [PC_W-1:0]   ret_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [PC_W-1:0]   fetch_addr_o,
  output logic [BYTE_W-1:0] reg_rdata_o
);

  localparam int UP_W = PC_W - 2 * BYTE_W;

  load_src_e         src;
  logic [PC_W-1:0]   pc;
  logic [BYTE_W-1:0] lat_hi;
  logic [UP_W-1:0]   lat_up;
  logic              swlo_wr;
  logic              lo_rd;
  logic              wr_hi;
  logic              wr_up;

  assign swlo_wr = reg_wr_i && (reg_sel_i == SEL_PC_LO);
  assign lo_rd   = reg_rd_i && (reg_sel_i == SEL_PC_LO);
  assign wr_hi   = reg_wr_i && (reg_sel_i == SEL_LAT_HI);
  assign wr_up   = reg_wr_i && (reg_sel_i == SEL_LAT_UP);

  pcl_src_arb u_arb (
    .adv     (adv_i),
    .jmp_vld (jmp_vld_i),
    .ret_vld (ret_vld_i),
    .swlo_wr (swlo_wr),
    .src     (src)
  );

  pcl_count_reg #(
    .PC_W       (PC_W),
    .BYTE_W     (BYTE_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .src      (src),
    .jmp_addr (jmp_addr_i),
    .ret_addr (ret_addr_i),
    .lat_up   (lat_up),
    .lat_hi   (lat_hi),
    .wdata    (reg_wdata_i),
    .pc       (pc)
  );

  pcl_latch_bank #(
    .BYTE_W (BYTE_W),
    .UP_W   (UP_W)
  ) u_lat (
    .clk       (clk),
    .rst       (rst),
    .cap_lo_rd (lo_rd),
    .pc_upper  (pc[PC_W-1:BYTE_W]),
    .wr_hi     (wr_hi),
    .wr_up     (wr_up),
    .hi_wdata  (reg_wdata_i),
    .up_wdata  (reg_wdata_i[UP_W-1:0]),
    .lat_hi    (lat_hi),
    .lat_up    (lat_up)
  );

  pcl_rd_port #(
    .BYTE_W (BYTE_W),
    .UP_W   (UP_W)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (reg_rd_i),
    .sel    (reg_sel_i),
    .pc_lo  (pc[BYTE_W-1:0]),
    .lat_hi (lat_hi),
    .lat_up (lat_up),
    .rdata  (reg_rdata_o)
  );

  assign fetch_addr_o = pc;

endmodule

// File: rtl/pcl_checker.sv
module pcl_checker
  import pcl_pkg::*;
#(
  parameter int PC_W   = DEF_PC_W,
  parameter int BYTE_W = DEF_BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              adv_i,
  input logic              jmp_vld_i,
  input logic [PC_W-1:0]   jmp_addr_i,
  input logic              ret_vld_i,
  input logic [PC_W-1:0]   ret_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [SEL_W-1:0]  reg_sel_i,
  input logic [BYTE_W-1:0] reg_wdata_i,
  input logic [PC_W-1:0]   fetch_addr_o,
  input logic [BYTE_W-1:0] reg_rdata_o
);

  localparam int UP_W = PC_W - 2 * BYTE_W;

  logic sw_lo;
  assign sw_lo = reg_wr_i && (reg_sel_i == SEL_PC_LO);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (fetch_addr_o == '0) && (reg_rdata_o == '0)); // R1

  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    fetch_addr_o[0] == 1'b0); // R2

  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !jmp_vld_i && !ret_vld_i && !sw_lo)
      |=> fetch_addr_o == $past(fetch_addr_o) + PC_W'(2)); // R2

  AST_SWLO_BYTE: assert property (@(posedge clk) disable iff (rst)
    (sw_lo && !jmp_vld_i && !ret_vld_i)
      |=> fetch_addr_o[BYTE_W-1:0] == ($past(reg_wdata_i) & ~BYTE_W'(1))); // R3

  AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    (jmp_vld_i && !ret_vld_i)
      |=> fetch_addr_o == ($past(jmp_addr_i) & ~PC_W'(1))); // R5

  AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (rst)
    ret_vld_i |=> fetch_addr_o == ($past(ret_addr_i) & ~PC_W'(1))); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !jmp_vld_i && !ret_vld_i && !sw_lo) |=> $stable(fetch_addr_o)); // R7

  AST_CNT_BYTES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && (reg_sel_i == SEL_PC_HI || reg_sel_i == SEL_PC_UP))
      |=> reg_rdata_o == '0); // R8

  AST_UPLAT_NARROW: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && reg_sel_i == SEL_LAT_UP)
      |=> reg_rdata_o[BYTE_W-1:UP_W] == '0); // R9

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_i |=> $stable(reg_rdata_o)); // R10

endmodule

bind pc_byte_counter pcl_checker #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/pc_byte_counter_tb.sv
module pc_byte_counter_tb;

  localparam int PC_W   = 21;
  localparam int BYTE_W = 8;
  localparam int PC_MASK = (1 << PC_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              adv_i = 1'b0;
  logic              jmp_vld_i = 1'b0;
  logic [PC_W-1:0]   jmp_addr_i = '0;
  logic              ret_vld_i = 1'b0;
  logic [PC_W-1:0]   ret_addr_i = '0;
  logic              reg_wr_i = 1'b0;
  logic              reg_rd_i = 1'b0;
  logic [2:0]        reg_sel_i = '0;
  logic [BYTE_W-1:0] reg_wdata_i = '0;
  logic [PC_W-1:0]   fetch_addr_o;
  logic [BYTE_W-1:0] reg_rdata_o;

  always #2 clk = ~clk;

  pc_byte_counter u_dut (
    .clk          (clk),
    .rst          (rst),
    .adv_i        (adv_i),
    .jmp_vld_i    (jmp_vld_i),
    .jmp_addr_i   (jmp_addr_i),
    .ret_vld_i    (ret_vld_i),
    .ret_addr_i   (ret_addr_i),
    .reg_wr_i     (reg_wr_i),
    .reg_rd_i     (reg_rd_i),
    .reg_sel_i    (reg_sel_i),
    .reg_wdata_i  (reg_wdata_i),
    .fetch_addr_o (fetch_addr_o),
    .reg_rdata_o  (reg_rdata_o)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cycles   = 0;
  bit    armed    = 1'b0;
  bit    finished = 1'b0;
  string cur_req  = "R1";

  // Behavioural reference model
  int m_pc = 0, m_hl = 0, m_ul = 0, m_rd = 0;
  int n_pc, n_hl, n_ul, n_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0; m_hl = 0; m_ul = 0; m_rd = 0;
    end else begin
      n_hl = m_hl; n_ul = m_ul; n_rd = m_rd;
      if (reg_rd_i) begin
        case (reg_sel_i)
          3'd0: begin
            n_rd = m_pc % 256;
            n_hl = (m_pc / 256) % 256;
            n_ul = (m_pc / 65536) % 32;
          end
          3'd3:    n_rd = m_hl;
          3'd4:    n_rd = m_ul;
          default: n_rd = 0;
        endcase
      end
      if (reg_wr_i && !(reg_rd_i && reg_sel_i == 3'd0)) begin
        if (reg_sel_i == 3'd3) n_hl = int'(reg_wdata_i);
        if (reg_sel_i == 3'd4) n_ul = int'(reg_wdata_i) % 32;
      end
      if (ret_vld_i)
        n_pc = int'(ret_addr_i) & (PC_MASK - 1);
      else if (jmp_vld_i)
        n_pc = int'(jmp_addr_i) & (PC_MASK - 1);
      else if (reg_wr_i && reg_sel_i == 3'd0)
        n_pc = (m_ul * 65536 + m_hl * 256 + int'(reg_wdata_i)) & (PC_MASK - 1);
      else if (adv_i)
        n_pc = (m_pc + 2) & PC_MASK;
      else
        n_pc = m_pc;
      m_pc = n_pc; m_hl = n_hl; m_ul = n_ul; m_rd = n_rd;
    end
    armed = 1'b1;
  end

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !finished) begin
      chk(int'(fetch_addr_o), m_pc, cur_req, "fetch address vs model");
      chk(int'(reg_rdata_o), m_rd, cur_req, "read data vs model");
    end
  end

  task automatic drive(input bit adv, input bit jv, input int ja, input bit rv, input int ra,
                       input bit wr, input bit rd, input int sel, input int wd);
    @(posedge clk); #1;
    adv_i = adv; jmp_vld_i = jv; jmp_addr_i = PC_W'(ja);
    ret_vld_i = rv; ret_addr_i = PC_W'(ra);
    reg_wr_i = wr; reg_rd_i = rd; reg_sel_i = 3'(sel); reg_wdata_i = BYTE_W'(wd);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // read a register and return value seen after the edge
  task automatic rd_reg(input int sel, output int val);
    drive(0, 0, 0, 0, 0, 0, 1, sel, 0);
    idle();
    val = int'(reg_rdata_o);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  initial begin
    int v;
    // R1 reset
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle();
    chk(int'(fetch_addr_o), 0, "R1", "counter after reset");
    chk(int'(reg_rdata_o), 0, "R1", "read data after reset");

    // R2 advance
    cur_req = "R2";
    repeat (6) drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle();
    chk(int'(fetch_addr_o), 12, "R2", "six advances");

    // R5 branch to odd address near top, then R2 wrap
    cur_req = "R5";
    drive(0, 1, 'h1FFFF9, 0, 0, 0, 0, 0, 0);
    idle();
    chk(int'(fetch_addr_o), 'h1FFFF8, "R5", "branch clears bit 0");
    cur_req = "R2";
    repeat (4) drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle();
    chk(int'(fetch_addr_o), 0, "R2", "wrap past top");

    // R9/R10 latch writes and reads
    cur_req = "R10";
    drive(0, 0, 0, 0, 0, 1, 0, 3, 'h34);
    drive(0, 0, 0, 0, 0, 1, 0, 4, 'hFF);
    rd_reg(3, v);
    chk(v, 'h34, "R10", "high latch readback");
    cur_req = "R9";
    rd_reg(4, v);
    chk(v, 'h1F, "R9", "upper latch drops bits 7:5");
    chk(int'(fetch_addr_o), 0, "R10", "latch access leaves counter");

    // R3 low-byte write
    cur_req = "R3";
    drive(0, 0, 0, 0, 0, 1, 0, 0, 'h57);
    idle();
    chk(int'(fetch_addr_o), 'h1F3456, "R3", "computed load");

    // R5 branch keeps latches
    cur_req = "R5";
    drive(0, 1, 'h0ABCDE, 0, 0, 0, 0, 0, 0);
    rd_reg(3, v);
    chk(v, 'h34, "R5", "high latch untouched by branch");

    // R4 low read refreshes latches
    cur_req = "R4";
    rd_reg(0, v);
    chk(v, 'hDE, "R4", "low byte readback");
    rd_reg(3, v);
    chk(v, 'hBC, "R4", "high latch captured");
    rd_reg(4, v);
    chk(v, 'h0A, "R4", "upper latch captured");

    // R6 return keeps latches
    cur_req = "R6";
    drive(0, 0, 0, 1, 'h123457, 0, 0, 0, 0);
    idle();
    chk(int'(fetch_addr_o), 'h123456, "R6", "return load");
    rd_reg(4, v);
    chk(v, 'h0A, "R6", "upper latch untouched by return");

    // R7 priorities
    cur_req = "R7";
    drive(1, 1, 'h000100, 1, 'h000200, 1, 0, 0, 'h77);
    idle();
    chk(int'(fetch_addr_o), 'h000200, "R7", "return beats branch");
    drive(1, 1, 'h000300, 0, 0, 1, 0, 0, 'h77);
    idle();
    chk(int'(fetch_addr_o), 'h000300, "R7", "branch beats low write");
    drive(1, 0, 0, 0, 0, 1, 0, 0, 'h40);
    idle();
    chk(int'(fetch_addr_o), 'h0ABC40, "R7", "low write beats advance");
    drive(0, 0, 0, 0, 0, 1, 1, 0, 'h10);
    idle();
    chk(int'(reg_rdata_o), 'h40, "R7", "read and write of low byte together");

    // R8 counter byte selects read zero, writes ignored
    cur_req = "R8";
    drive(0, 0, 0, 0, 0, 1, 0, 1, 'hAA);
    drive(0, 0, 0, 0, 0, 1, 0, 2, 'hAA);
    drive(0, 0, 0, 0, 0, 1, 0, 6, 'hAA);
    rd_reg(1, v);
    chk(v, 0, "R8", "counter high select");
    rd_reg(2, v);
    chk(v, 0, "R8", "counter upper select");
    rd_reg(7, v);
    chk(v, 0, "R8", "unused select");
    chk(int'(fetch_addr_o), 'h0ABC10, "R8", "counter untouched by ignored writes");

    // R1 reset mid-run
    cur_req = "R1";
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    idle();
    chk(int'(fetch_addr_o), 0, "R1", "counter after second reset");
    rd_reg(3, v);
    chk(v, 0, "R1", "high latch after reset");

    repeat (3) idle();
    summary();
  end

endmodule